// File: doc/BRIEF.md
# TDM Highway Time-Slot Selector

This block joins a serial time-division multiplexed highway to a fixed internal frame of 32 byte slots. The highway runs at one, two or four times the base rate, so it carries 32, 64 or 128 eight-bit slots per frame. Only one slot in each group of one, two or four consecutive highway slots belongs to this device. A sub-slot offset picks which one, and the receive and transmit directions each have their own offset. The highway frame is 256, 512 or 1024 bit periods long.

On receive, the block samples the serial data line once per enabled bit-clock cycle. It assembles the bits of its chosen slots most significant bit first, and hands each complete byte to the internal side with a one-clock strobe and the internal slot index 0 to 31. On transmit, it asks the internal side for the byte of the next chosen slot one bit period ahead, and then shifts that byte out. The output enable is raised only while a chosen slot is on the line; in every other slot the highway driver must be left in high impedance.

A rising edge on frame sync aligns the bit position counter. Normally the edge marks bit 0 of highway slot 0. With the delay option set, the edge marks the last bit of the previous frame. A frame sync at an unexpected position realigns the counter. Without frame sync, the counter wraps by itself at the frame length.

Top module: `tdm_slot_sel`

## Requirements
- R1: While reset is asserted and right after it, `rx_valid` and `tx_oe` are 0.
- R2: With `rate_sel` = 0 (32 slots), internal slot n is highway slot n for n = 0..31, and both sub-slot selects are ignored.
- R3: With `rate_sel` = 1 (64 slots), internal slot n is highway slot 2n + s, where s is bit 0 of the sub-slot select; bit 1 of the select is ignored.
- R4: With `rate_sel` = 2 or 3 (128 slots), internal slot n is highway slot 4n + k, where k = 0..3 is the sub-slot select. For example, with k = 2, internal slot 3 is highway slot 14.
- R5: With `fs_delay` = 0, the enabled bit cycle in which `fsync` is first seen high after being low carries bit 0 of highway slot 0.
- R6: With `fs_delay` = 1, that cycle carries the last bit of the frame, and bit 0 of slot 0 follows in the next enabled cycle.
- R7: The receive offset `rx_sub` and the transmit offset `tx_sub` act independently within the same group.
- R8: Bits are received MSB first. One clock after the enabled cycle that samples bit 7 of a selected slot, `rx_valid` is high for exactly one clock, together with the byte on `rx_byte` and the internal slot on `rx_slot`.
- R9: `tx_req` is high, with the internal slot on `tx_req_slot`, in the enabled cycle just before bit 0 of a selected transmit slot, and `tx_byte` is sampled in that cycle. `tx_dout` then presents that byte MSB first, one bit per enabled cycle. `tx_oe` is 1 exactly during selected transmit slots, and `tx_dout` is 1 whenever `tx_oe` is 0.
- R10: A frame-sync edge at any position realigns the counter as in R5 and R6. With no frame sync, the counter wraps to 0 after the last bit of the frame, which is 256, 512 or 1024 bits long according to the rate.
- R11: In cycles with `bit_en` low, no data bit is sampled or sent, and the position counter and the transmit outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-period enable; one highway bit per enabled cycle |
| fsync | input | 1 | Frame sync, sampled on enabled cycles |
| rate_sel | input | 2 | 0: 32 slots, 1: 64 slots, 2 or 3: 128 slots |
| rx_sub | input | 2 | Receive sub-slot offset |
| tx_sub | input | 2 | Transmit sub-slot offset |
| fs_delay | input | 1 | Frame-sync one-bit delay option |
| rx_din | input | 1 | Highway serial receive data |
| tx_byte | input | 8 | Byte for the slot named by `tx_req_slot` |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 5 | Internal slot of the received byte |
| tx_req | output | 1 | Transmit byte request |
| tx_req_slot | output | 5 | Internal slot being requested |
| tx_dout | output | 1 | Highway serial transmit data |
| tx_oe | output | 1 | Highway driver enable; 0 means high impedance |

## Verification
The hardest case to reach is a frame sync that lands away from the frame boundary. It happens while `bit_en` is stretched irregularly, and sometimes in the middle of a selected slot, so a byte is cut short on one side and the counter restarts on the other. The bench gets there by driving its frame generator with a random enable pattern and then moving its own bit position forward by 37 bits partway through a run. Other runs use the delay option and omit frame sync altogether. A behavioural model tracks the position from the same pins and predicts every strobe, byte, slot index and transmit bit on every clock.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_BITS  = 8;
  localparam int BASE_SLOTS = 32;
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int ISLOT_W    = $clog2(BASE_SLOTS);
  localparam int MAX_SHIFT  = 2;

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X2  = 2'd1,
    RATE_X4  = 2'd2,
    RATE_X4B = 2'd3
  } rate_e;

  // log2 of the highway slots per internal slot
  function automatic logic [1:0] rate_shift(input logic [1:0] r);
    case (rate_e'(r))
      RATE_X1: return 2'd0;
      RATE_X2: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/tdm_bit_timer.sv
module tdm_bit_timer #(
  parameter int ISW   = tdm_pkg::ISLOT_W,
  parameter int BW    = tdm_pkg::BIT_W,
  parameter int MAXSH = tdm_pkg::MAX_SHIFT,
  localparam int PW   = ISW + BW + MAXSH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          fsync,
  input  logic [1:0]    shift,
  input  logic          dly,
  output logic [PW-1:0] cur_pos,
  output logic [PW-1:0] nxt_pos
);
  logic [PW-1:0] cnt_q, cnt_d, last;
  logic          fs_q, fs_d, fs_edge;

  always_comb begin
    last    = PW'((1 << (ISW + BW + int'(shift))) - 1);
    fs_edge = fsync & ~fs_q;
    if (fs_edge) cur_pos = dly ? last : '0;
    else         cur_pos = cnt_q;
    nxt_pos = (cur_pos >= last) ? '0 : cur_pos + PW'(1);
    cnt_d   = bit_en ? nxt_pos : cnt_q;
    fs_d    = bit_en ? fsync : fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
    end
  end

  // R5
  fs_nodly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync && !fs_q && !dly |=> cnt_q == PW'(1));
  // R6
  fs_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync && !fs_q && dly |=> cnt_q == '0);
  // R10
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> cnt_q <= $past(last));
  // R11
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q));
endmodule

// File: rtl/tdm_slot_match.sv
module tdm_slot_match #(
  parameter int ISW   = tdm_pkg::ISLOT_W,
  parameter int BW    = tdm_pkg::BIT_W,
  parameter int MAXSH = tdm_pkg::MAX_SHIFT,
  localparam int PW   = ISW + BW + MAXSH,
  localparam int HW   = ISW + MAXSH
) (
  input  logic [PW-1:0]  pos,
  input  logic [1:0]     shift,
  input  logic [1:0]     sub,
  output logic           hit,
  output logic [ISW-1:0] islot,
  output logic [BW-1:0]  bit_idx
);
  logic [HW-1:0]  hslot;
  logic [MAXSH:0] hit_v;
  logic [ISW-1:0] isl_v [MAXSH+1];

  assign hslot   = pos[PW-1:BW];
  assign bit_idx = pos[BW-1:0];

  for (genvar g = 0; g <= MAXSH; g++) begin : g_rate
    localparam int M = (1 << g) - 1;
    always_comb begin
      hit_v[g] = ((int'(hslot) >> (ISW + g)) == 0) &&
                 ((int'(hslot) & M) == (int'(sub) & M));
      isl_v[g] = ISW'(int'(hslot) >> g);
    end
  end

  always_comb begin
    hit   = 1'b0;
    islot = '0;
    for (int i = 0; i <= MAXSH; i++) begin
      if (int'(shift) == i) begin
        hit   = hit_v[i];
        islot = isl_v[i];
      end
    end
  end
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int ISW  = tdm_pkg::ISLOT_W,
  parameter int BW   = tdm_pkg::BIT_W,
  localparam int SB  = 1 << BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           din,
  input  logic           hit,
  input  logic [BW-1:0]  bit_idx,
  input  logic [ISW-1:0] islot,
  output logic           valid_q,
  output logic [SB-1:0]  byte_q,
  output logic [ISW-1:0] slot_q
);
  logic [SB-1:0]  sh_q, sh_d, byte_d;
  logic [ISW-1:0] slot_d;
  logic           valid_d;

  always_comb begin
    sh_d    = sh_q;
    valid_d = 1'b0;
    byte_d  = byte_q;
    slot_d  = slot_q;
    if (bit_en && hit) begin
      sh_d = {sh_q[SB-2:0], din};
      if (bit_idx == BW'(SB - 1)) begin
        valid_d = 1'b1;
        byte_d  = sh_d;
        slot_d  = islot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      byte_q  <= '0;
      slot_q  <= '0;
    end else begin
      sh_q    <= sh_d;
      valid_q <= valid_d;
      byte_q  <= byte_d;
      slot_q  <= slot_d;
    end
  end

  // R8
  rx_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(bit_en) && $past(hit));
  // R8
  rx_lsb_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> byte_q[0] == $past(din));
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int ISW  = tdm_pkg::ISLOT_W,
  parameter int BW   = tdm_pkg::BIT_W,
  localparam int SB  = 1 << BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           hit_n,
  input  logic [BW-1:0]  bit_n,
  input  logic [ISW-1:0] islot_n,
  input  logic [SB-1:0]  tx_byte,
  output logic           tx_req,
  output logic [ISW-1:0] tx_req_slot,
  output logic           dout_q,
  output logic           oe_q
);
  logic [SB-1:0] sh_q, sh_d;
  logic          dout_d, oe_d;

  always_comb begin
    tx_req      = bit_en && hit_n && (bit_n == '0);
    tx_req_slot = islot_n;
    sh_d   = sh_q;
    dout_d = dout_q;
    oe_d   = oe_q;
    if (bit_en) begin
      if (hit_n) begin
        oe_d = 1'b1;
        if (bit_n == '0) begin
          dout_d = tx_byte[SB-1];
          sh_d   = {tx_byte[SB-2:0], 1'b0};
        end else begin
          dout_d = sh_q[SB-1];
          sh_d   = {sh_q[SB-2:0], 1'b0};
        end
      end else begin
        oe_d   = 1'b0;
        dout_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      dout_q <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      dout_q <= dout_d;
      oe_q   <= oe_d;
    end
  end

  // R9
  tx_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> oe_q && (dout_q == $past(tx_byte[SB-1])));
  // R9
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> dout_q);
  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(oe_q) && $stable(dout_q));
endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel #(
  parameter int ISW   = tdm_pkg::ISLOT_W,
  parameter int BW    = tdm_pkg::BIT_W,
  parameter int MAXSH = tdm_pkg::MAX_SHIFT,
  localparam int PW   = ISW + BW + MAXSH,
  localparam int SB   = 1 << BW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           fsync,
  input  logic [1:0]     rate_sel,
  input  logic [1:0]     rx_sub,
  input  logic [1:0]     tx_sub,
  input  logic           fs_delay,
  input  logic           rx_din,
  input  logic [SB-1:0]  tx_byte,
  output logic           rx_valid,
  output logic [SB-1:0]  rx_byte,
  output logic [ISW-1:0] rx_slot,
  output logic           tx_req,
  output logic [ISW-1:0] tx_req_slot,
  output logic           tx_dout,
  output logic           tx_oe
);
  logic [1:0]     shift;
  logic [PW-1:0]  cur_pos, nxt_pos;
  logic           rx_hit, tx_hit;
  logic [ISW-1:0] rx_isl, tx_isl;
  logic [BW-1:0]  rx_bit, tx_bit;

  assign shift = tdm_pkg::rate_shift(rate_sel);

  tdm_bit_timer #(.ISW(ISW), .BW(BW), .MAXSH(MAXSH)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .shift(shift), .dly(fs_delay), .cur_pos(cur_pos), .nxt_pos(nxt_pos));

  tdm_slot_match #(.ISW(ISW), .BW(BW), .MAXSH(MAXSH)) u_rx_match (
    .pos(cur_pos), .shift(shift), .sub(rx_sub),
    .hit(rx_hit), .islot(rx_isl), .bit_idx(rx_bit));

  tdm_slot_match #(.ISW(ISW), .BW(BW), .MAXSH(MAXSH)) u_tx_match (
    .pos(nxt_pos), .shift(shift), .sub(tx_sub),
    .hit(tx_hit), .islot(tx_isl), .bit_idx(tx_bit));

  tdm_rx_deser #(.ISW(ISW), .BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(rx_din),
    .hit(rx_hit), .bit_idx(rx_bit), .islot(rx_isl),
    .valid_q(rx_valid), .byte_q(rx_byte), .slot_q(rx_slot));

  tdm_tx_ser #(.ISW(ISW), .BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .hit_n(tx_hit), .bit_n(tx_bit), .islot_n(tx_isl), .tx_byte(tx_byte),
    .tx_req(tx_req), .tx_req_slot(tx_req_slot),
    .dout_q(tx_dout), .oe_q(tx_oe));

  // R8
  rx_tx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rx_hit));
endmodule

// File: tb/sim_tdm_slot_sel.sv
`timescale 1ns/1ps
module sim_tdm_slot_sel;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, bit_en, fsync, fs_delay, rx_din;
  logic [1:0] rate_sel, rx_sub, tx_sub;
  logic [7:0] tx_byte, rx_byte;
  logic [4:0] rx_slot, tx_req_slot;
  logic       rx_valid, tx_req, tx_dout, tx_oe;

  tdm_slot_sel u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .rate_sel(rate_sel), .rx_sub(rx_sub), .tx_sub(tx_sub),
    .fs_delay(fs_delay), .rx_din(rx_din), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot),
    .tx_req(tx_req), .tx_req_slot(tx_req_slot),
    .tx_dout(tx_dout), .tx_oe(tx_oe));

  function automatic logic [7:0] pat(input logic [4:0] s);
    return 8'(int'(s) * 37 + 90);
  endfunction
  assign tx_byte = pat(tx_req_slot);

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference
  int mcnt, mrsh, mtsh, eb, es;
  bit mfs, ev, eoe, edo;

  function automatic int shof(input int r);
    return (r == 0) ? 0 : ((r == 1) ? 1 : 2);
  endfunction
  function automatic bit msel(input int p, input int sub, input int sh);
    int hs = p / 8;
    if (sh == 0) return hs < 32;
    if (sh == 1) return (hs < 64) && ((hs % 2) == (sub % 2));
    return (hs < 128) && ((hs % 4) == sub);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; mfs = 0; mrsh = 0; mtsh = 0;
      ev = 0; eoe = 0; edo = 1; eb = 0; es = 0;
    end else begin
      ev = 0;
      if (bit_en) begin
        int sh, len, p, n;
        sh  = shof(int'(rate_sel));
        len = 256 << sh;
        p   = (fsync && !mfs) ? (fs_delay ? len - 1 : 0) : mcnt;
        mfs = fsync;
        if (msel(p, int'(rx_sub), sh)) begin
          mrsh = ((mrsh << 1) | int'(rx_din)) & 255;
          if (p % 8 == 7) begin
            ev = 1; eb = mrsh; es = (p / 8) >> sh;
          end
        end
        n = (p + 1 >= len) ? 0 : p + 1;
        if (msel(n, int'(tx_sub), sh)) begin
          eoe = 1;
          if (n % 8 == 0) mtsh = int'(pat(5'((n / 8) >> sh)));
          edo  = mtsh[7];
          mtsh = (mtsh << 1) & 255;
        end else begin
          eoe = 0; edo = 1;
        end
        mcnt = n;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rx_valid == ev, "R8 rx_valid", int'(rx_valid), int'(ev));
    if (ev) begin
      chk(int'(rx_byte) == eb, "R8 rx_byte", int'(rx_byte), eb);
      chk(int'(rx_slot) == es, "R8 rx_slot", int'(rx_slot), es);
    end
    chk(tx_oe == eoe, "R9 tx_oe", int'(tx_oe), int'(eoe));
    if (eoe) chk(tx_dout == edo, "R9 tx_dout", int'(tx_dout), int'(edo));
    else     chk(tx_dout == 1'b1, "R9 idle tx_dout", int'(tx_dout), 1);
  endtask

  // fsm: 0 regular frame sync, 1 none, 2 regular plus a jump
  task automatic run_cfg(input int r, input int rxs, input int txs, input int d,
                         input int enm, input int fsm, input int nfr, input string t);
    int len, gpos, nbits;
    rate_sel = 2'(r); rx_sub = 2'(rxs); tx_sub = 2'(txs); fs_delay = d[0];
    bit_en = 0; fsync = 0; rx_din = 0;
    @(negedge clk); rst_n = 0;
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      chk(rx_valid == 0, "R1 reset rx_valid", int'(rx_valid), 0);
      chk(tx_oe == 0, "R1 reset tx_oe", int'(tx_oe), 0);
    end
    rst_n = 1;
    tag = t;
    len = 256 << shof(r);
    gpos = (fsm == 1) ? 5 : 0;
    nbits = 0;
    while (nbits < len * nfr) begin
      @(negedge clk);
      compare();
      bit_en = (enm == 0) ? 1'b1 : (($urandom % 3) != 0);
      if (bit_en) begin
        rx_din = 1'($urandom);
        fsync  = (fsm != 1) && (gpos == 0);
        gpos   = (gpos + 1) % len;
        nbits++;
        if (fsm == 2 && nbits == len + len / 2) gpos = (gpos + 37) % len;
      end
    end
    repeat (4) begin
      @(negedge clk);
      compare();
      bit_en = 0;
    end
  endtask

  initial begin
    rst_n = 0; bit_en = 0; fsync = 0; fs_delay = 0; rx_din = 0;
    rate_sel = 0; rx_sub = 0; tx_sub = 0;
    run_cfg(0, 3, 1, 0, 0, 0, 3, "R2 R5");
    run_cfg(1, 1, 0, 0, 0, 0, 3, "R3 R7");
    run_cfg(1, 3, 2, 0, 1, 0, 2, "R3 R11");
    run_cfg(2, 2, 1, 0, 0, 0, 3, "R4 R7");
    run_cfg(3, 3, 0, 1, 0, 0, 2, "R4 R6");
    run_cfg(1, 0, 1, 0, 1, 2, 3, "R10 resync");
    run_cfg(0, 0, 0, 1, 0, 1, 3, "R10 free-wrap R6");
    run_cfg(2, 0, 2, 1, 1, 2, 3, "R11 R10");
    run_cfg(0, 1, 2, 0, 0, 2, 3, "R5 R10");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule